// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block keeps the four-state coherence tag (Modified, Exclusive, Shared, Invalid) and a one-word data copy for every line of one cache. The cache shares a broadcast bus with peer caches and a memory controller. Each line index is also the line's address, so no tag compare and no replacement choice is made. The block serves its own core's read, write and evict requests. It issues bus transactions through an arbiter when coherence requires them. It also watches the address phases of its peers and answers each one.

A peer read or read-for-ownership that hits a dirty line is answered on the fixed response cycle with a hit-modified flag and the line's data. That one transfer feeds the requester directly, and the memory controller captures it from the same bus cycle. No retry and no separate write-back are needed.

The bus runs in a fixed rhythm. A grant is followed by one address-phase cycle, which is followed by one response cycle. Snoop responses always appear exactly one cycle after the snooped address phase.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` is low and no snoop response (`snp_shared`, `snp_hitm`) is driven; a snooped read of any line gets no response.
- R2: A read (`req_op`=0) to a line in S, E or M completes in the cycle it is presented, with no bus request, returning the stored word.
- R3: A read miss issues bus command 0 (read); the returned `rsp_data_i` is the read result, and the line is installed Exclusive when neither `rsp_shared_i` nor `rsp_hitm_i` is set in the response cycle, Shared otherwise.
- R4: A write (`req_op`=1) to a line in E or M completes in the cycle it is presented, without bus traffic, and leaves the line Modified with the new word.
- R5: A write to a Shared line issues command 2 (invalidate); a write to an Invalid line issues command 1 (read-for-ownership); both end with the line Modified holding the written word.
- R6: One cycle after a snooped address phase (`snp_valid`), `snp_shared` is high when the line is E or S and the command is read; `snp_hitm` is high, with the line's word on `snp_data`, when the line is M and the command is read or read-for-ownership; the two are never high together, and the word seen there is what memory receives.
- R7: A snooped read downgrades an M or E line to Shared.
- R8: A snooped read-for-ownership or invalidate moves the line to Invalid.
- R9: Evicting (`req_op`=2) a Modified line issues command 3 (write-back) carrying the line index on `bus_addr` and the word on `bus_wdata`, then leaves it Invalid; evicting an E, S or I line completes at once with no bus traffic and leaves it Invalid.
- R10: A local request is not accepted in a cycle where `snp_valid` is high; it completes in the next free cycle.
- R11: The bus command is fixed in the address phase from the line's state at that time: a write whose Shared line was invalidated while waiting for the grant issues read-for-ownership, and an evict whose Modified line was snooped away issues no transaction.
- R12: `bus_req` stays high until `bus_gnt`; the address phase (`bus_valid`) lasts exactly the cycle after the grant, and `rsp_*_i` are sampled in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present, held until `req_done` |
| req_op | input | 2 | 0 read, 1 write, 2 evict |
| req_addr | input | AW | Line index |
| req_wdata | input | DW | Write word |
| req_done | output | 1 | Request completes at this clock edge |
| req_rdata | output | DW | Read result, valid with `req_done` |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | One-cycle grant |
| bus_valid | output | 1 | Own address phase |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_addr | output | AW | Address-phase line index |
| bus_wdata | output | DW | Write-back word |
| rsp_shared_i | input | 1 | Some peer holds the line clean |
| rsp_hitm_i | input | 1 | A peer held the line Modified |
| rsp_data_i | input | DW | Line word from a peer or memory |
| snp_valid | input | 1 | Peer address phase |
| snp_cmd | input | 2 | Peer command, same encoding as `bus_cmd` |
| snp_addr | input | AW | Peer line index |
| snp_shared | output | 1 | Clean-hit response |
| snp_hitm | output | 1 | Dirty-hit response |
| snp_data | output | DW | Implicit write-back word |

## Verification
The bench builds the block with its defaults, AW=3 and DW=32. Eight lines let each scenario work on its own line, so the states left behind by one test never disturb another. Distinct 32-bit words make every data path identifiable: a fill from the bus, a local write, an implicit write-back seen by the memory model, and an explicit write-back. The bench holds back the grant for two cycles and injects a peer snoop into that gap. This brings the late command decision and the held request within reach.

// File: rtl/mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl #(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_done,
  output logic [DW-1:0] req_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_valid,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          rsp_shared_i,
  input  logic          rsp_hitm_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_shared,
  output logic          snp_hitm,
  output logic [DW-1:0] snp_data
);
  localparam int NL = 1 << AW;
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_EV = 2'd2;
  localparam logic [1:0] C_RD = 2'd0, C_RFO = 2'd1, C_UPG = 2'd2, C_WB = 2'd3;

  typedef enum logic [1:0] {ST_I, ST_S, ST_E, ST_M} mesi_t;
  typedef enum logic [1:0] {F_IDLE, F_REQ, F_ADDR, F_RESP} fsm_t;

  mesi_t         lst  [NL];
  logic [DW-1:0] ldat [NL];
  fsm_t          fs;
  logic [1:0]    cmd_q;
  logic          used_q;

  mesi_t cur, sst;
  logic  need_bus, idle_go, addr_need;
  logic [1:0] cmd_now;

  assign cur = lst[req_addr];
  assign sst = lst[snp_addr];

  always_comb begin
    case (req_op)
      OP_RD:   need_bus = (cur == ST_I);
      OP_WR:   need_bus = (cur == ST_I) || (cur == ST_S);
      OP_EV:   need_bus = (cur == ST_M);
      default: need_bus = 1'b0;
    endcase
  end

  always_comb begin
    case (req_op)
      OP_RD:   cmd_now = C_RD;
      OP_WR:   cmd_now = (cur == ST_S) ? C_UPG : C_RFO;
      default: cmd_now = C_WB;
    endcase
  end

  assign addr_need = (req_op == OP_EV) ? (cur == ST_M) : 1'b1;
  assign idle_go   = (fs == F_IDLE) && req_valid && !snp_valid;
  assign req_done  = (idle_go && !need_bus) || (fs == F_RESP);
  assign req_rdata = (fs == F_RESP) ? rsp_data_i : ldat[req_addr];
  assign bus_req   = (fs == F_REQ);
  assign bus_valid = (fs == F_ADDR) && addr_need;
  assign bus_cmd   = cmd_now;
  assign bus_addr  = req_addr;
  assign bus_wdata = ldat[req_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs     <= F_IDLE;
      cmd_q  <= C_RD;
      used_q <= 1'b0;
      for (int i = 0; i < NL; i++) lst[i] <= ST_I;
    end else begin
      case (fs)
        F_IDLE: if (idle_go) begin
          if (need_bus) fs <= F_REQ;
          else if (req_op == OP_WR) lst[req_addr] <= ST_M;
          else if (req_op == OP_EV) lst[req_addr] <= ST_I;
        end
        F_REQ: if (bus_gnt) fs <= F_ADDR;
        F_ADDR: begin
          fs     <= F_RESP;
          cmd_q  <= cmd_now;
          used_q <= addr_need;
        end
        default: begin
          fs <= F_IDLE;
          if (!used_q) lst[req_addr] <= ST_I;
          else case (cmd_q)
            C_RD:        lst[req_addr] <= (rsp_shared_i || rsp_hitm_i) ? ST_S : ST_E;
            C_RFO, C_UPG: lst[req_addr] <= ST_M;
            default:     lst[req_addr] <= ST_I;
          endcase
        end
      endcase
      if (snp_valid) begin
        case (snp_cmd)
          C_RD:         if (sst != ST_I) lst[snp_addr] <= ST_S;
          C_RFO, C_UPG: lst[snp_addr] <= ST_I;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (idle_go && !need_bus && req_op == OP_WR)
      ldat[req_addr] <= req_wdata;
    else if (fs == F_RESP && used_q) begin
      if (cmd_q == C_RD) ldat[req_addr] <= rsp_data_i;
      else if (cmd_q == C_RFO || cmd_q == C_UPG) ldat[req_addr] <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snp_shared <= 1'b0;
      snp_hitm   <= 1'b0;
      snp_data   <= '0;
    end else begin
      snp_shared <= snp_valid && snp_cmd == C_RD && (sst == ST_S || sst == ST_E);
      snp_hitm   <= snp_valid && (snp_cmd == C_RD || snp_cmd == C_RFO) && sst == ST_M;
      snp_data   <= (snp_valid && sst == ST_M) ? ldat[snp_addr] : '0;
    end
  end

  // R6
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hitm || snp_shared) |-> $past(snp_valid));
  // R6
  rsp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hitm |-> !snp_shared);
  // R10
  snoop_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !req_done);
  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);
  // R12
  addr_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $past(bus_gnt));
  // R5
  upg_from_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == C_UPG) |-> lst[bus_addr] == ST_S);
  // R9
  wb_from_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == C_WB) |-> lst[bus_addr] == ST_M);
endmodule

// File: tb/tb_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_snoop_ctrl;
  localparam int AW = 3;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0; logic [1:0] req_op = 0; logic [AW-1:0] req_addr = 0; logic [DW-1:0] req_wdata = 0;
  logic req_done; logic [DW-1:0] req_rdata;
  logic bus_req, bus_gnt = 0, bus_valid; logic [1:0] bus_cmd; logic [AW-1:0] bus_addr; logic [DW-1:0] bus_wdata;
  logic rsp_shared_i = 0, rsp_hitm_i = 0; logic [DW-1:0] rsp_data_i = 0;
  logic snp_valid = 0; logic [1:0] snp_cmd = 0; logic [AW-1:0] snp_addr = 0;
  logic snp_shared, snp_hitm; logic [DW-1:0] snp_data;

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [8];
  logic [AW-1:0] prev_snp_addr;
  logic inj_sh, inj_hm; logic [DW-1:0] inj_d;

  always #10 clk = ~clk;

  mesi_snoop_ctrl #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_done(req_done), .req_rdata(req_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rsp_shared_i(rsp_shared_i), .rsp_hitm_i(rsp_hitm_i),
    .rsp_data_i(rsp_data_i), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_hitm(snp_hitm), .snp_data(snp_data));

  always @(posedge clk) begin
    prev_snp_addr <= snp_addr;
    if (snp_hitm) mem[prev_snp_addr] <= snp_data;
    if (bus_valid && bus_cmd == 2'd3) mem[bus_addr] <= bus_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input bit sh, input bit hm, input logic [DW-1:0] rd,
                         input bit inj, input logic [1:0] icmd,
                         output logic [DW-1:0] rdata, output bit used, output logic [1:0] cmd,
                         output logic [DW-1:0] wbd, output int ncyc);
    int gi; bit fin;
    req_valid = 1; req_op = op; req_addr = a; req_wdata = wd;
    used = 0; cmd = 0; wbd = 0; gi = -10; fin = 0; ncyc = -1; rdata = 0;
    for (int i = 0; i < 30 && !fin; i++) begin
      if (i == gi + 2) begin rsp_shared_i = sh; rsp_hitm_i = hm; rsp_data_i = rd; end
      if (inj && i == 1) begin snp_valid = 1; snp_cmd = icmd; snp_addr = a; end
      #1;
      if (bus_valid) begin
        chk(i == gi + 1, "R12 address phase cycle", i, gi + 1);
        chk(bus_addr == a, "R12 address", bus_addr, a);
        used = 1; cmd = bus_cmd; wbd = bus_wdata;
      end
      if (inj && i == 2) begin
        inj_sh = snp_shared; inj_hm = snp_hitm; inj_d = snp_data;
        chk(bus_req == 1, "R12 request held", bus_req, 1);
      end
      if (req_done) begin rdata = req_rdata; fin = 1; ncyc = i; end
      else if (bus_req && gi < 0 && !(inj && i < 3)) begin bus_gnt = 1; gi = i; end
      @(negedge clk);
      bus_gnt = 0; snp_valid = 0; rsp_shared_i = 0; rsp_hitm_i = 0; rsp_data_i = 0;
    end
    req_valid = 0;
    if (!fin) chk(0, "R12 request never completed", 0, 1);
  endtask

  task automatic do_snoop(input logic [1:0] c, input logic [AW-1:0] a,
                          output logic sh, output logic hm, output logic [DW-1:0] d);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    #1 sh = snp_shared; hm = snp_hitm; d = snp_data;
    @(negedge clk);
  endtask

  logic [DW-1:0] rdv, wbv, sd; bit used; logic [1:0] cmd; int nc; logic sh, hm;

  task automatic t_reset();
    chk(bus_req == 0, "R1 bus_req idle", bus_req, 0);
    chk(snp_hitm == 0 && snp_shared == 0, "R1 no response", {snp_hitm, snp_shared}, 0);
    do_snoop(2'd0, 3'd0, sh, hm, sd);
    chk(sh == 0 && hm == 0, "R1 snoop on invalid line", {hm, sh}, 0);
  endtask

  task automatic t_read_excl();
    run_req(2'd0, 3'd1, 0, 0, 0, 32'hA1A1_0001, 0, 0, rdv, used, cmd, wbv, nc);
    chk(used && cmd == 2'd0, "R3 read miss issues read", {used, cmd}, {1'b1, 2'd0});
    chk(rdv == 32'hA1A1_0001, "R3 fill data", rdv, 32'hA1A1_0001);
    do_snoop(2'd0, 3'd1, sh, hm, sd);
    chk(sh == 1 && hm == 0, "R6 clean hit on exclusive", {hm, sh}, 1);
    run_req(2'd0, 3'd1, 0, 0, 0, 0, 0, 0, rdv, used, cmd, wbv, nc);
    chk(!used && nc == 0, "R2 read hit no bus", {used, nc[7:0]}, 0);
    chk(rdv == 32'hA1A1_0001, "R2 hit data", rdv, 32'hA1A1_0001);
    run_req(2'd1, 3'd1, 32'hB1B1_0001, 0, 0, 0, 0, 0, rdv, used, cmd, wbv, nc);
    chk(used && cmd == 2'd2, "R7 E downgraded so write invalidates (R5)", cmd, 2);
    do_snoop(2'd0, 3'd1, sh, hm, sd);
    chk(hm == 1 && sh == 0 && sd == 32'hB1B1_0001, "R6 dirty hit supplies data", sd, 32'hB1B1_0001);
    chk(mem[1] == 32'hB1B1_0001, "R6 memory observes transfer", mem[1], 32'hB1B1_0001);
    do_snoop(2'd1, 3'd1, sh, hm, sd);
    chk(hm == 0 && sh == 0, "R7 M downgraded to S", {hm, sh}, 0);
    run_req(2'd0, 3'd1, 0, 0, 0, 32'hC1, 0, 0, rdv, used, cmd, wbv, nc);
    chk(used && cmd == 2'd0 && rdv == 32'hC1, "R8 invalidated line misses", {used, cmd}, {1'b1, 2'd0});
  endtask

  task automatic t_read_shared();
    run_req(2'd0, 3'd2, 0, 1, 0, 32'h22, 0, 0, rdv, used, cmd, wbv, nc);
    run_req(2'd1, 3'd2, 32'h2222, 0, 0, 0, 0, 0, rdv, used, cmd, wbv, nc);
    chk(used && cmd == 2'd2, "R3 shared response installs S", cmd, 2);
    run_req(2'd0, 3'd6, 0, 0, 1, 32'h66, 0, 0, rdv, used, cmd, wbv, nc);
    chk(rdv == 32'h66, "R3 peer dirty data", rdv, 32'h66);
    run_req(2'd1, 3'd6, 32'h6666, 0, 0, 0, 0, 0, rdv, used, cmd, wbv, nc);
    chk(used && cmd == 2'd2, "R3 hitm response installs S", cmd, 2);
  endtask

  task automatic t_silent_upgrade();
    run_req(2'd0, 3'd3, 0, 0, 0, 32'h33, 0, 0, rdv, used, cmd, wbv, nc);
    run_req(2'd1, 3'd3, 32'h3333, 0, 0, 0, 0, 0, rdv, used, cmd, wbv, nc);
    chk(!used && nc == 0, "R4 write to E silent", used, 0);
    run_req(2'd1, 3'd3, 32'h3334, 0, 0, 0, 0, 0, rdv, used, cmd, wbv, nc);
    chk(!used && nc == 0, "R4 write to M silent", used, 0);
    do_snoop(2'd1, 3'd3, sh, hm, sd);
    chk(hm == 1 && sd == 32'h3334, "R4 line modified with data (R6)", sd, 32'h3334);
    run_req(2'd0, 3'd3, 0, 0, 0, 32'h35, 0, 0, rdv, used, cmd, wbv, nc);
    chk(used && cmd == 2'd0, "R8 RFO snoop invalidates", {used, cmd}, {1'b1, 2'd0});
  endtask

  task automatic t_write_miss_evict();
    run_req(2'd1, 3'd4, 32'h4444, 0, 0, 32'h40, 0, 0, rdv, used, cmd, wbv, nc);
    chk(used && cmd == 2'd1, "R5 write miss issues RFO", cmd, 1);
    do_snoop(2'd0, 3'd4, sh, hm, sd);
    chk(hm == 1 && sd == 32'h4444, "R5 written word held Modified", sd, 32'h4444);
    run_req(2'd2, 3'd4, 0, 0, 0, 0, 0, 0, rdv, used, cmd, wbv, nc);
    chk(!used && nc == 0, "R9 clean evict silent", used, 0);
    do_snoop(2'd0, 3'd4, sh, hm, sd);
    chk(sh == 0 && hm == 0, "R9 clean evict leaves I", {hm, sh}, 0);
    run_req(2'd1, 3'd5, 32'h5555, 0, 0, 0, 0, 0, rdv, used, cmd, wbv, nc);
    run_req(2'd2, 3'd5, 0, 0, 0, 0, 0, 0, rdv, used, cmd, wbv, nc);
    chk(used && cmd == 2'd3 && wbv == 32'h5555, "R9 dirty evict write-back", wbv, 32'h5555);
    @(negedge clk);
    chk(mem[5] == 32'h5555, "R9 memory updated", mem[5], 32'h5555);
    run_req(2'd0, 3'd5, 0, 0, 0, 32'h55, 0, 0, rdv, used, cmd, wbv, nc);
    chk(used && cmd == 2'd0, "R9 evicted line invalid", {used, cmd}, {1'b1, 2'd0});
  endtask

  task automatic t_late_decision();
    run_req(2'd0, 3'd7, 0, 1, 0, 32'h77, 0, 0, rdv, used, cmd, wbv, nc);
    run_req(2'd1, 3'd7, 32'h7777, 0, 0, 32'h70, 1, 2'd2, rdv, used, cmd, wbv, nc);
    chk(used && cmd == 2'd1, "R11 lost S becomes RFO", cmd, 1);
    chk(inj_hm == 0 && inj_sh == 0, "R6 no response to invalidate", {inj_hm, inj_sh}, 0);
    run_req(2'd1, 3'd0, 32'hD0D0, 0, 0, 0, 0, 0, rdv, used, cmd, wbv, nc);
    run_req(2'd2, 3'd0, 0, 0, 0, 0, 1, 2'd0, rdv, used, cmd, wbv, nc);
    chk(inj_hm == 1 && inj_d == 32'hD0D0, "R11 snoop served during wait", inj_d, 32'hD0D0);
    chk(!used, "R11 dropped write-back", used, 0);
    chk(mem[0] == 32'hD0D0, "R6 memory took implicit write-back", mem[0], 32'hD0D0);
    do_snoop(2'd0, 3'd0, sh, hm, sd);
    chk(sh == 0 && hm == 0, "R11 line ends invalid", {hm, sh}, 0);
  endtask

  task automatic t_snoop_stall();
    req_valid = 1; req_op = 2'd0; req_addr = 3'd7;
    snp_valid = 1; snp_cmd = 2'd0; snp_addr = 3'd2;
    #1 chk(req_done == 0, "R10 held off during snoop", req_done, 0);
    @(negedge clk);
    snp_valid = 0;
    #1 chk(req_done == 1 && req_rdata == 32'h7777, "R10 completes next cycle", req_rdata, 32'h7777);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_read_excl();
    t_read_shared();
    t_silent_upgrade();
    t_write_miss_evict();
    t_late_decision();
    t_snoop_stall();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule